// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block gathers the pending-event flags of a timer's secondary interrupt sources: four capture/compare channels, the counter overflow and two spare slots. It turns them into one read-only vector word. The word holds an even offset that names the most urgent enabled source, so an interrupt handler can add the word straight to a jump table. The first capture/compare channel that the timer has is not part of this vector. That channel keeps its own separate interrupt path, which always outranks this one.

Any bus access to the vector address removes exactly one event, the one the word reports at that moment. A read and a write both count as an access. Every other pending flag is left untouched, and the combined request output stays high while any enabled flag remains. In this way one handler entry serves one source, and the next handler entry follows at once.

Each source has its own enable bit. A flag whose enable bit is low stays latched, but it is hidden from the vector and from the request until it is enabled again.

Top module: `ivr_vector_unit`

## Requirements
- R1: While `rst_n` is low, all flags are cleared, `vec_o` reads 0 and `irq_o` is 0. Asserting `rst_n` takes effect at once, without a clock edge.
- R2: A high bit on `set_i` for one clock edge latches that source's flag. From that edge on, `vec_o` reports the flag if the source is enabled.
- R3: Source k of `set_i` is reported as 2*(k+1). Bit 0 is channel 1 (2), bit 1 is channel 2 (4), bit 2 is channel 3 (6), bit 3 is channel 4 (8), bit 4 is overflow (10), and bits 5 and 6 are the spare slots (12 and 14). Bit 0 of `vec_o` and all bits above bit 3 always read 0.
- R4: When several enabled flags are pending, the one with the lowest `set_i` index is reported.
- R5: `vec_o` is 0 when no flag is both pending and enabled.
- R6: A flag whose bit in `en_i` is 0 stays latched. It does not appear in `vec_o` or `irq_o`, and it appears again as soon as its enable bit is set.
- R7: A cycle with `acc_rd_i` high clears only the flag reported by `vec_o` in that cycle. All other flags keep their state.
- R8: A cycle with `acc_wr_i` high has the same effect as a read. It clears the reported flag and nothing else, and it carries no data into the vector.
- R9: If a source's set pulse arrives in the same cycle as the access that would clear it, the flag stays set.
- R10: An access while `vec_o` is 0 changes no flag, including flags that are pending but disabled.
- R11: `irq_o` is registered. After each clock edge it equals the OR of (flags AND `en_i`) as they stood just before that edge.
- R12: With channels 2 and 3 pending, the first read sees 4. After that read the word shows 6 and `irq_o` stays high, so a second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_i | input | NUM_SRC | One-cycle set pulses, one per source |
| en_i | input | NUM_SRC | Per-source enable mask |
| acc_rd_i | input | 1 | One-cycle read strobe of the vector address |
| acc_wr_i | input | 1 | One-cycle write strobe of the vector address |
| vec_o | output | VEC_W | Vector word: even offset of the top enabled pending source, or 0 |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear and a set that land on the same flag in the same cycle. That case needs a flag that is already the top pending source, an access strobe, and a fresh set pulse for that same source, all on one edge. The stimulus table first leaves only a spare-slot flag pending. It then issues a read while it pulses channel 1, and then another read while it pulses channel 1 again, so the second read targets a flag that is being set at the same moment. A masked flag that survives an access to an empty vector is reached by disabling its source just before the access and enabling it again afterwards.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  // Offset reported for source index idx: 2*(idx+1)
  function automatic logic [15:0] src_code(input int unsigned idx);
    logic [15:0] r;
    r = 16'((idx + 1) * 2);
    return r;
  endfunction

endpackage

// File: rtl/ivr_rst_sync.sv
module ivr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/ivr_flag_bank.sv
module ivr_flag_bank #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;
  logic [NUM_SRC-1:0] load;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    // set has priority over clear so no event is lost
    always_comb begin
      load[k]   = set_i[k] | clr_i[k];
      flag_d[k] = set_i[k] | (flag_q[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else if (load[k]) begin
        flag_q[k] <= flag_d[k];
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ivr_prio_enc.sv
module ivr_prio_enc
  import ivr_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int VEC_W   = 16
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o
);

  localparam int CODE_W = $clog2(2 * NUM_SRC + 1);

  logic [CODE_W-1:0] code;

  // lowest index wins: scan from lowest priority upward, last hit stays
  always_comb begin
    grant_o = '0;
    code    = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        grant_o = '0;
        grant_o[k] = 1'b1;
        code    = CODE_W'(src_code(k));
      end
    end
  end

  always_comb begin
    vec_o = '0;
    vec_o[CODE_W-1:0] = code;
  end

endmodule

// File: rtl/ivr_irq_reg.sv
module ivr_irq_reg #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               irq_o
);

  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/ivr_vector_unit.sv
module ivr_vector_unit #(
  parameter int NUM_SRC = 7,
  parameter int VEC_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               acc_rd_i,
  input  logic               acc_wr_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               irq_o
);

  logic               rst_q_n;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr;
  logic               access;

  ivr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  ivr_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (set_i),
    .clr_i  (clr),
    .flag_o (flag_q)
  );

  always_comb begin
    active = flag_q & en_i;
    access = acc_rd_i | acc_wr_i;
    clr    = access ? grant : '0;
  end

  ivr_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .req_i   (active),
    .grant_o (grant),
    .vec_o   (vec_o)
  );

  ivr_irq_reg #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .req_i (active),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/ivr_vector_unit_chk.sv
module ivr_vector_unit_chk #(
  parameter int NUM_SRC = 7,
  parameter int VEC_W   = 16
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [NUM_SRC-1:0] set_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               acc_rd_i,
  input logic               acc_wr_i,
  input logic [VEC_W-1:0]   vec_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] grant
);

  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(grant));

  p_empty_vec_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((flag_q & en_i) == '0) |-> (vec_o == '0));

  p_irq_high_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vec_o != '0) |=> irq_o);

  p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vec_o == '0) |=> !irq_o);

  p_clear_hit_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((acc_rd_i || acc_wr_i) && (grant != '0) && ((set_i & grant) == '0))
    |=> ((flag_q & $past(grant)) == '0));

  p_keep_others_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((flag_q & $past(flag_q) & ~$past(grant)) == ($past(flag_q) & ~$past(grant))));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  p_idle_access_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((acc_rd_i || acc_wr_i) && (grant == '0) && (set_i == '0)) |=> $stable(flag_q));

endmodule

bind ivr_vector_unit ivr_vector_unit_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .set_i    (set_i),
  .en_i     (en_i),
  .acc_rd_i (acc_rd_i),
  .acc_wr_i (acc_wr_i),
  .vec_o    (vec_o),
  .irq_o    (irq_o),
  .flag_q   (flag_q),
  .grant    (grant)
);

// File: tb/ivr_vector_unit_bench.sv
`timescale 1ns/1ps
module ivr_vector_unit_bench;

  localparam int N  = 7;
  localparam int VW = 16;

  typedef struct packed {
    logic [6:0] set;
    logic [6:0] en;
    logic       rd;
    logic       wr;
    logic [3:0] vec;
    logic       irq;
    logic [3:0] req;
  } step_t;

  // expected vec/irq are sampled after the edge that applies the step
  localparam step_t TBL [26] = '{
    '{7'h00, 7'h7F, 1'b0, 1'b0, 4'd0,  1'b0, 4'd5},   // R5 nothing pending
    '{7'h06, 7'h7F, 1'b0, 1'b0, 4'd4,  1'b0, 4'd2},   // R2 ch2+ch3 latched
    '{7'h00, 7'h7F, 1'b0, 1'b0, 4'd4,  1'b1, 4'd11},  // R11 irq one edge later
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd6,  1'b1, 4'd7},   // R7 read clears ch2 only
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd0,  1'b1, 4'd7},   // R7 read clears ch3
    '{7'h00, 7'h7F, 1'b0, 1'b0, 4'd0,  1'b0, 4'd11},  // R11 irq drops
    '{7'h50, 7'h7F, 1'b0, 1'b0, 4'd10, 1'b0, 4'd3},   // R3 overflow=10
    '{7'h00, 7'h7F, 1'b0, 1'b1, 4'd14, 1'b1, 4'd8},   // R8 write clears overflow
    '{7'h00, 7'h3F, 1'b0, 1'b0, 4'd0,  1'b0, 4'd6},   // R6 masked spare
    '{7'h00, 7'h3F, 1'b1, 1'b0, 4'd0,  1'b0, 4'd10},  // R10 empty access
    '{7'h00, 7'h7F, 1'b0, 1'b0, 4'd14, 1'b1, 4'd6},   // R6 re-enabled, survived
    '{7'h01, 7'h7F, 1'b1, 1'b0, 4'd2,  1'b1, 4'd9},   // R9 clear spare, set ch1
    '{7'h01, 7'h7F, 1'b1, 1'b0, 4'd2,  1'b1, 4'd9},   // R9 set beats clear
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd0,  1'b1, 4'd7},
    '{7'h08, 7'h7F, 1'b0, 1'b0, 4'd8,  1'b0, 4'd3},   // R3 ch4=8
    '{7'h20, 7'h7F, 1'b0, 1'b0, 4'd8,  1'b1, 4'd4},   // R4 ch4 over spare
    '{7'h00, 7'h7F, 1'b0, 1'b1, 4'd12, 1'b1, 4'd8},   // R8 spare=12
    '{7'h7F, 7'h7F, 1'b0, 1'b0, 4'd2,  1'b1, 4'd4},   // R4 all pending
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd4,  1'b1, 4'd4},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd6,  1'b1, 4'd4},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd8,  1'b1, 4'd4},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd10, 1'b1, 4'd4},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd12, 1'b1, 4'd4},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd14, 1'b1, 4'd3},
    '{7'h00, 7'h7F, 1'b1, 1'b0, 4'd0,  1'b1, 4'd7},
    '{7'h00, 7'h7F, 1'b0, 1'b0, 4'd0,  1'b0, 4'd11}
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  set_i;
  logic [N-1:0]  en_i;
  logic          acc_rd_i;
  logic          acc_wr_i;
  logic [VW-1:0] vec_o;
  logic          irq_o;

  int checks;
  int failures;
  bit done;

  ivr_vector_unit #(.NUM_SRC(N), .VEC_W(VW)) u_ivr_vector_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_i),
    .en_i     (en_i),
    .acc_rd_i (acc_rd_i),
    .acc_wr_i (acc_wr_i),
    .vec_o    (vec_o),
    .irq_o    (irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; set_i = '0; en_i = '1; acc_rd_i = 1'b0; acc_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(vec_o == 0, "R1", int'(vec_o), 0);
    chk(irq_o == 1'b0, "R1", int'(irq_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < 26; i++) begin
      set_i = TBL[i].set; en_i = TBL[i].en;
      acc_rd_i = TBL[i].rd; acc_wr_i = TBL[i].wr;
      @(posedge clk);
      @(negedge clk);
      chk(vec_o == VW'(TBL[i].vec), $sformatf("R%0d step %0d vec", TBL[i].req, i),
          int'(vec_o), int'(TBL[i].vec));
      chk(irq_o == TBL[i].irq, $sformatf("R%0d step %0d irq", TBL[i].req, i),
          int'(irq_o), int'(TBL[i].irq));
      chk((vec_o[0] == 1'b0) && ((vec_o >> 4) == 0), "R3 shape", int'(vec_o), 0);
    end
    set_i = '0; acc_rd_i = 1'b0; acc_wr_i = 1'b0; en_i = '1;

    // R12: value seen during the read strobe itself
    set_i = 7'h06;
    @(negedge clk);
    set_i = '0;
    acc_rd_i = 1'b1;
    #1;
    chk(vec_o == 4, "R12 first read", int'(vec_o), 4);
    @(negedge clk);
    #1;
    chk(vec_o == 6, "R12 second read", int'(vec_o), 6);
    chk(irq_o == 1'b1, "R12 request held", int'(irq_o), 1);
    @(negedge clk);
    acc_rd_i = 1'b0;
    chk(vec_o == 0, "R12 drained", int'(vec_o), 0);

    // R1: asynchronous reset while flags pending
    set_i = 7'h7F;
    @(negedge clk);
    set_i = '0;
    @(negedge clk);
    chk(irq_o == 1'b1, "R1 pre-reset irq", int'(irq_o), 1);
    #1 rst_n = 1'b0;
    #1;
    chk(vec_o == 0, "R1 async vec", int'(vec_o), 0);
    chk(irq_o == 1'b0, "R1 async irq", int'(irq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vec_o == 0, "R1 after release", int'(vec_o), 0);

    done = 1'b1;
    summary();
  end

endmodule